// File: doc/BRIEF.md
# Shuffled Lookup Scheduler with Random Dummy Padding

This block tells a block-cipher datapath which substitution slot to work on in each cycle. The aim is to hide when each real lookup happens. When an execution is accepted, the block draws a random number P of leading decoy operations. The rest of a fixed decoy budget runs after the real work. Each round visits all real lookup slots once, in an order drawn again for that round. The order comes from an incremental Fisher-Yates shuffle: one swap per real operation, fed by an internal 16-bit LFSR. A draw that falls outside the remaining range is folded back into it, so each real operation always takes one cycle.

On a decoy operation the block raises the decoy write strobe, and the datapath updates its spare decoy registers. On a real operation it raises the real write strobe, and exactly one real state slot is written. An option lets the block skip operation cycles at random, which disturbs the timing further. The number of operations per execution never changes. With skipping turned off, the number of busy cycles never changes either.

Top module: `shuffle_dummy_sched`

## Requirements
- R1: After reset, busy, done, op_valid, real_we and decoy_we are all low.
- R2: A start pulse seen while busy is low begins an execution, and busy is high in the following cycle.
- R3: Every execution issues exactly NSLOT*ROUNDS+DUMMIES operations (cycles with op_valid high). With SKIP_EN=0, busy stays high for exactly that many cycles.
- R4: Exactly DUMMIES operations of each execution are decoys (op_real=0). P of them come before the first real operation and DUMMIES-P after the last one, so the real operations form one unbroken run. P changes between executions.
- R5: Each group of NSLOT consecutive real operations presents every slot index 0..NSLOT-1 on op_slot exactly once. The order differs between rounds.
- R6: On a real operation real_we=1 and decoy_we=0. On a decoy operation real_we=0 and decoy_we=1. When op_valid is low both strobes are low.
- R7: done is high for exactly one cycle, the cycle right after the last operation, and busy is low in that cycle.
- R8: A start pulse while busy is high has no effect. The running execution keeps its operation count and gives only one done pulse, and busy stays low after it.
- R9: With SKIP_EN=1 some busy cycles carry no operation, and the operation count of R3 still holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a new execution; ignored while busy |
| busy | output | 1 | An execution is in progress |
| done | output | 1 | One-cycle pulse after the final operation |
| op_valid | output | 1 | An operation is issued this cycle |
| op_real | output | 1 | 1 = real lookup, 0 = decoy operation |
| op_slot | output | $clog2(NSLOT) | Slot index of the operation |
| real_we | output | 1 | Write enable for the real state slot op_slot |
| decoy_we | output | 1 | Write enable for the decoy registers |

## Verification
The bench builds two copies with NSLOT=16, ROUNDS=2 and DUMMIES=8, giving 40 operations per execution. One copy has SKIP_EN=1 and the other SKIP_EN=0, and each has its own seed. The skipping copy shows that the operation count holds while cycle timing varies. The non-skipping copy makes the exact busy-cycle count observable. Two rounds per execution make it possible to compare shuffled orders between rounds. Several executions in a row show the prefix split moving.

// File: rtl/sds_pkg.sv
package sds_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;

  // Galois right-shift LFSR step
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    logic [LFSR_W-1:0] n;
    n = s >> 1;
    if (s[0]) n = n ^ LFSR_TAPS;
    return n;
  endfunction

  // Value in [0, span-1]: mask the draw to the smallest covering power of two,
  // then fold an out-of-range result back by one span.
  function automatic logic [LFSR_W-1:0] pick_below(input logic [LFSR_W-1:0] r,
                                                   input int unsigned span);
    logic [LFSR_W-1:0] m;
    logic [LFSR_W-1:0] v;
    int unsigned lim;
    lim = (span == 0) ? 0 : span - 1;
    m = '0;
    for (int b = 0; b < LFSR_W; b++)
      if ((lim >> b) != 0) m[b] = 1'b1;
    v = r & m;
    if (32'(v) >= span) v = v - LFSR_W'(span);
    return v;
  endfunction
endpackage

// File: rtl/sds_lfsr.sv
module sds_lfsr
  import sds_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [LFSR_W-1:0] rnd
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rnd <= SEED;
    else        rnd <= lfsr_step(rnd);
  end
endmodule

// File: rtl/sds_perm.sv
module sds_perm
  import sds_pkg::*;
#(
  parameter int NSLOT = 16,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SW-1:0]     step,
  input  logic [LFSR_W-1:0] draw,
  input  logic              take,
  output logic [SW-1:0]     slot
);
  logic [SW-1:0] tbl [NSLOT];
  logic [LFSR_W-1:0] off;
  logic [SW-1:0] pick_idx;

  always_comb begin
    off      = pick_below(draw, NSLOT - int'(step));
    pick_idx = step + off[SW-1:0];
    slot     = tbl[pick_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NSLOT; k++) tbl[k] <= SW'(k);
    end else if (take) begin
      tbl[step]     <= tbl[pick_idx];
      tbl[pick_idx] <= tbl[step];
    end
  end
endmodule

// File: rtl/sds_ctrl.sv
module sds_ctrl
  import sds_pkg::*;
#(
  parameter int NSLOT   = 16,
  parameter int ROUNDS  = 2,
  parameter int DUMMIES = 8,
  parameter bit SKIP_EN = 1'b1,
  localparam int SW    = $clog2(NSLOT),
  localparam int NREAL = NSLOT * ROUNDS,
  localparam int TOTAL = NREAL + DUMMIES,
  localparam int CW    = $clog2(TOTAL + 1) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LFSR_W-1:0] rnd,
  output logic              busy,
  output logic              done,
  output logic              op_valid,
  output logic              op_real,
  output logic [SW-1:0]     step,
  output logic              last_op
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] pre;
  logic [CW-1:0] rel;
  logic          skip;

  always_comb begin
    skip     = SKIP_EN && (&rnd[LFSR_W-1:LFSR_W-3]);
    op_valid = busy && !skip;
    rel      = cnt - pre;
    op_real  = busy && (cnt >= pre) && (rel < CW'(NREAL));
    step     = rel[SW-1:0];
    last_op  = op_valid && (cnt == CW'(TOTAL - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      pre  <= '0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= '0;
          pre  <= CW'(pick_below(rnd, DUMMIES + 1));
        end
      end else if (op_valid) begin
        if (last_op) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/shuffle_dummy_sched.sv
module shuffle_dummy_sched
  import sds_pkg::*;
#(
  parameter int NSLOT   = 16,
  parameter int ROUNDS  = 2,
  parameter int DUMMIES = 8,
  parameter bit SKIP_EN = 1'b1,
  parameter logic [15:0] SEED = 16'hACE1,
  localparam int SW = $clog2(NSLOT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic          op_valid,
  output logic          op_real,
  output logic [SW-1:0] op_slot,
  output logic          real_we,
  output logic          decoy_we
);
  logic [LFSR_W-1:0] rnd;
  logic [SW-1:0]     step;
  logic [SW-1:0]     perm_slot;
  logic              real_take;
  logic              last_op;

  sds_lfsr #(.SEED(SEED)) lfsr_i (.clk(clk), .rst_n(rst_n), .rnd(rnd));

  sds_ctrl #(
    .NSLOT(NSLOT), .ROUNDS(ROUNDS), .DUMMIES(DUMMIES), .SKIP_EN(SKIP_EN)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .rnd(rnd),
    .busy(busy), .done(done), .op_valid(op_valid), .op_real(op_real),
    .step(step), .last_op(last_op)
  );

  assign real_take = op_valid && op_real;

  sds_perm #(.NSLOT(NSLOT)) perm_i (
    .clk(clk), .rst_n(rst_n), .step(step), .draw(rnd >> 4),
    .take(real_take), .slot(perm_slot)
  );

  // decoys present a random-looking slot index so they resemble real work
  assign op_slot  = op_real ? perm_slot : rnd[8 +: SW];
  assign real_we  = real_take;
  assign decoy_we = op_valid && !op_real;
endmodule

// File: rtl/shuffle_dummy_sched_chk.sv
module shuffle_dummy_sched_chk #(
  parameter int NSLOT   = 16,
  parameter int ROUNDS  = 2,
  parameter int DUMMIES = 8,
  localparam int SW    = $clog2(NSLOT),
  localparam int TOTAL = NSLOT * ROUNDS + DUMMIES
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          op_valid,
  input logic          op_real,
  input logic [SW-1:0] op_slot,
  input logic          real_we,
  input logic          decoy_we
);
  int unsigned ops_c;
  int unsigned dum_c;
  int unsigned rcount;
  logic [NSLOT-1:0] rmask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ops_c <= 0; dum_c <= 0; rcount <= 0; rmask <= '0;
    end else if (start && !busy) begin
      ops_c <= 0; dum_c <= 0; rcount <= 0; rmask <= '0;
    end else if (op_valid) begin
      ops_c <= ops_c + 1;
      if (decoy_we) dum_c <= dum_c + 1;
      if (real_we) begin
        if (rcount == NSLOT - 1) begin
          rcount <= 0; rmask <= '0;
        end else begin
          rcount <= rcount + 1;
          rmask[op_slot] <= 1'b1;
        end
      end
    end
  end

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_done_after_op: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($past(op_valid) && !busy));
  a_r3_total_ops: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ops_c == TOTAL));
  a_r4_dummy_count: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (dum_c == DUMMIES));
  a_r5_no_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    real_we |-> !rmask[op_slot]);
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> (real_we != decoy_we) && (real_we == op_real));
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (!real_we && !decoy_we));
  a_r8_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || done));
endmodule

bind shuffle_dummy_sched shuffle_dummy_sched_chk #(
  .NSLOT(NSLOT), .ROUNDS(ROUNDS), .DUMMIES(DUMMIES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .op_valid(op_valid), .op_real(op_real), .op_slot(op_slot),
  .real_we(real_we), .decoy_we(decoy_we)
);

// File: tb/shuffle_dummy_sched_tb_top.sv
`timescale 1ns/1ps
module sds_tb_mon #(parameter int N = 16) (
  input logic clk, busy, done, op_valid, op_real, real_we, decoy_we,
  input logic [$clog2(N)-1:0] op_slot
);
  int ops, dum, pre, post, busy_cyc, skips, done_cnt;
  int contig_err, perm_err, we_err, done_err, ridx, rounds_diff;
  bit seen_real, prev_valid, prev_done;
  bit [N-1:0] mask;
  int ord0 [N];

  task automatic clear();
    ops = 0; dum = 0; pre = 0; post = 0; busy_cyc = 0; skips = 0; done_cnt = 0;
    contig_err = 0; perm_err = 0; we_err = 0; done_err = 0; ridx = 0;
    rounds_diff = 0; seen_real = 0; prev_valid = 0; prev_done = 0; mask = '0;
  endtask

  initial clear();

  always @(negedge clk) begin
    if (op_valid) begin
      ops++;
      if (!op_real) begin
        dum++;
        if (!seen_real) pre++; else post++;
        if (real_we || !decoy_we) we_err++;
      end else begin
        if (post != 0) contig_err++;
        seen_real = 1;
        if (!real_we || decoy_we) we_err++;
        if (mask[op_slot]) perm_err++;
        mask[op_slot] = 1'b1;
        if (ridx < N) ord0[ridx] = int'(op_slot);
        else if (ord0[ridx % N] != int'(op_slot)) rounds_diff++;
        ridx++;
        if (ridx % N == 0) begin
          if (mask != '1) perm_err++;
          mask = '0;
        end
      end
    end else if (real_we || decoy_we) we_err++;
    if (busy) busy_cyc++;
    if (busy && !op_valid) skips++;
    if (done) begin
      done_cnt++;
      if (!prev_valid || busy || prev_done) done_err++;
    end
    prev_valid = op_valid;
    prev_done  = done;
  end
endmodule

module shuffle_dummy_sched_tb_top;
  localparam int N = 16, R = 2, D = 8, TOTAL = N * R + D;
  localparam int SW = $clog2(N);

  logic clk = 0, rst_n = 0, start = 0;
  logic a_busy, a_done, a_valid, a_real, a_rwe, a_dwe;
  logic b_busy, b_done, b_valid, b_real, b_rwe, b_dwe;
  logic [SW-1:0] a_slot, b_slot;

  int checks = 0, fails = 0, cycles = 0;
  int pre_hist [8];
  int skips_total = 0, order_diff_total = 0;

  always #2.5 clk = ~clk;

  shuffle_dummy_sched #(.NSLOT(N), .ROUNDS(R), .DUMMIES(D), .SKIP_EN(1'b1),
    .SEED(16'hACE1)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(a_busy), .done(a_done),
    .op_valid(a_valid), .op_real(a_real), .op_slot(a_slot),
    .real_we(a_rwe), .decoy_we(a_dwe));

  shuffle_dummy_sched #(.NSLOT(N), .ROUNDS(R), .DUMMIES(D), .SKIP_EN(1'b0),
    .SEED(16'h1D0F)) dut_ns (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(b_busy), .done(b_done),
    .op_valid(b_valid), .op_real(b_real), .op_slot(b_slot),
    .real_we(b_rwe), .decoy_we(b_dwe));

  sds_tb_mon #(.N(N)) mon_a (.clk(clk), .busy(a_busy), .done(a_done),
    .op_valid(a_valid), .op_real(a_real), .real_we(a_rwe), .decoy_we(a_dwe),
    .op_slot(a_slot));
  sds_tb_mon #(.N(N)) mon_b (.clk(clk), .busy(b_busy), .done(b_done),
    .op_valid(b_valid), .op_real(b_real), .real_we(b_rwe), .decoy_we(b_dwe),
    .op_slot(b_slot));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic wait_done();
    int n = 0;
    while (!(mon_a.done_cnt > 0 && mon_b.done_cnt > 0) && n < 2000) begin
      @(negedge clk); n++;
    end
    check("R7 done seen in time", int'(n < 2000), 1);
    repeat (3) @(negedge clk);
  endtask

  task automatic run_exec(input int idx, input bit poke_busy);
    @(negedge clk);
    mon_a.clear(); mon_b.clear();
    start = 1;
    @(negedge clk);
    start = 0;
    check("R2 busy after start A", int'(a_busy), 1);
    check("R2 busy after start B", int'(b_busy), 1);
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    wait_done();
    check("R3 op count A", mon_a.ops, TOTAL);
    check("R3 op count B", mon_b.ops, TOTAL);
    check("R3 busy cycles B no-skip", mon_b.busy_cyc, TOTAL);
    check("R4 dummy count A", mon_a.dum, D);
    check("R4 dummy count B", mon_b.dum, D);
    check("R4 prefix+suffix A", mon_a.pre + mon_a.post, D);
    check("R4 real run contiguous A", mon_a.contig_err + mon_b.contig_err, 0);
    check("R5 per-round permutation", mon_a.perm_err + mon_b.perm_err, 0);
    check("R6 write strobes", mon_a.we_err + mon_b.we_err, 0);
    check("R7 done pulse A", mon_a.done_cnt, 1);
    check("R7 done pulse B", mon_b.done_cnt, 1);
    check("R7 done timing", mon_a.done_err + mon_b.done_err, 0);
    check("R9 no skip in B", mon_b.skips, 0);
    if (poke_busy) begin
      check("R8 idle after ignored start A", int'(a_busy), 0);
      check("R8 idle after ignored start B", int'(b_busy), 0);
    end
    pre_hist[idx] = mon_a.pre;
    skips_total += mon_a.skips;
    order_diff_total += mon_a.rounds_diff + mon_b.rounds_diff;
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    check("R1 reset busy", int'(a_busy | b_busy), 0);
    check("R1 reset done", int'(a_done | b_done), 0);
    check("R1 reset op_valid", int'(a_valid | b_valid), 0);
    check("R1 reset strobes", int'(a_rwe | a_dwe | b_rwe | b_dwe), 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    check("R1 idle stays quiet", int'(a_busy | a_valid | b_busy | b_valid), 0);
  endtask

  task automatic test_split_varies();
    bit varied = 0;
    for (int i = 1; i < 8; i++) if (pre_hist[i] != pre_hist[0]) varied = 1;
    check("R4 prefix split varies", int'(varied), 1);
    check("R5 order differs between rounds", int'(order_diff_total > 0), 1);
    check("R9 skip cycles present in A", int'(skips_total > 0), 1);
  endtask

  initial begin
    test_reset();
    for (int i = 0; i < 7; i++) run_exec(i, 1'b0);
    run_exec(7, 1'b1);
    test_split_varies();
    finish_run();
  end
endmodule